// File: doc/BRIEF.md
# Configuration Register Target on a Two-Wire Serial Bus

This block lets a host controller reach a small bank of configuration registers over a two-wire serial bus (I2C). Both bus lines arrive as raw open-drain levels and are brought into the system clock domain by a synchronizer and a majority vote before any edge detection. The block answers to a seven-bit target address. Its upper five bits are fixed and its lower two come from strap inputs, so a board can place up to four such targets on one bus. A strap can also be moved at runtime to pick one target out of many.

A write transaction carries a pointer byte first and then any number of data bytes. Each data byte leaves the block as a one-cycle write strobe with a register index and a data value. A read transaction, usually reached through a repeated START after the pointer byte, streams register contents out starting at the current pointer. After every data byte, in either direction, the pointer moves to the next index. The register storage sits outside the block. The block presents the pointer as a read index and takes the selected value back on a read-data input.

Timing against SCL is done in system clocks. An incoming bit is taken a fixed number of clocks after the filtered SCL rise. The SDA pull-down changes only a fixed number of clocks after the filtered SCL fall.

Top module: `cfg_i2c_target`

## Requirements
- R1: The block answers only to the address whose bits, from most significant down, are 1,0,0,0,1, then addr_strap[1], then addr_strap[0]. The address byte carries these seven bits first and the direction bit last. Any other address gets no acknowledge and causes no register write.
- R2: Out of reset and after a STOP, the block ignores all SCL/SDA activity until a START (SDA falling while SCL is high). While idle, sda_drive_low stays 0.
- R3: On an address match, the block pulls SDA low during the ninth SCL clock of the address byte. A direction bit of 1 selects read and 0 selects write.
- R4: In a write transaction, the first data byte loads the pointer. Each later byte produces a single-cycle reg_wr_stb, with reg_wr_addr set to the pointer and reg_wr_data set to the byte.
- R5: The pointer advances by one after every data byte read or written. A 28-byte read from pointer 0x00 returns registers 0x00 to 0x1B in order.
- R6: When the pointer is 28 (0x1C) or above, a written byte gives no strobe and a read byte returns 0x00 whatever reg_rd_data holds.
- R7: A STOP (SDA rising while SCL is high) releases SDA and ends the transaction. A repeated START begins a new address phase and keeps the pointer.
- R8: The SDA pull-down changes only while SCL is low, a delay after SCL falls. Host bits are taken a delay after SCL rises.
- R9: If the host answers a read byte with NACK, the block releases SDA and stays quiet until the next STOP or START.
- R10: The block acknowledges every data byte of a write transaction, including bytes it discards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Raw SCL bus level |
| sda_in | input | 1 | Raw SDA bus level |
| addr_strap | input | 2 | Low two bits of the target address |
| sda_drive_low | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_rd_addr | output | 8 | Current pointer, index of the register to read |
| reg_rd_data | input | 8 | Register value at reg_rd_addr |
| reg_wr_stb | output | 1 | One-cycle register write strobe |
| reg_wr_addr | output | 8 | Register index for the write |
| reg_wr_data | output | 8 | Data for the write |

## Verification
The address phase is swept over every strap setting against every value of the two low address bits. A wrong fixed prefix and clocking with no START are also tried, which separates a correct address compare from one that ignores the straps or the START rule. A full 28-register write with distinct values, followed by a read through a repeated START, shows whether the pointer loads and advances and whether the two directions share it. Writing and reading at the end of the map exposes the range limit and the zero read value. A read closed by NACK, then one extra clock, shows whether SDA is released. A monitor counts any SDA drive change while SCL is high.

// File: rtl/cfgi2c_pkg.sv
// Shared types and constants for the configuration register target.
package cfgi2c_pkg;
    // Transaction phase of the target.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_WAIT
    } phase_t;

    // Fixed upper part of the seven-bit target address.
    localparam logic [4:0] ADDR_PREFIX = 5'b10001;
endpackage

// File: rtl/i2c_line_filter.sv
// Brings one open-drain bus line into the clock domain: a synchronizer
// chain followed by a majority vote over the last few synchronized samples.
// Assumes the idle bus level is high; resets to 1.
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int VOTE_TAPS   = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);
    localparam int HALF = VOTE_TAPS / 2;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [VOTE_TAPS-1:0]   hist_q;
    logic                   vote_hi;

    // Synchronizer chain and sample history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
            hist_q <= {hist_q[VOTE_TAPS-2:0], sync_q[SYNC_STAGES-1]};
        end
    end

    // Majority decision over the history window.
    always_comb begin
        int ones;
        ones = 0;
        for (int i = 0; i < VOTE_TAPS; i++) ones += int'(hist_q[i]);
        vote_hi = (ones > HALF);
    end

    // Registered filtered level.
    always_ff @(posedge clk) begin
        if (!rst_n) line_out <= 1'b1;
        else        line_out <= vote_hi;
    end
endmodule

// File: rtl/i2c_delay_pulse.sv
// Emits a single-cycle pulse DELAY clocks after a trigger; a new trigger
// restarts the count. Assumes DELAY >= 1.
module i2c_delay_pulse #(
    parameter int DELAY = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse
);
    localparam int CW = $clog2(DELAY + 1);

    logic [CW-1:0] cnt_q;

    // Countdown from DELAY to zero after each trigger.
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (trig)            cnt_q <= CW'(DELAY);
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign pulse = (cnt_q == CW'(1));
endmodule

// File: rtl/cfg_i2c_target.sv
// Two-wire bus target giving a host access to an external register bank.
// Filters SCL/SDA, detects START/STOP and SCL edges, takes host bits a
// fixed delay after SCL rise and updates its SDA pull-down a fixed delay
// after SCL fall. The register pointer is loaded by the first write byte
// and advances after each data byte. Assumes the SCL half period is well
// above the filter latency plus either delay.
module cfg_i2c_target
    import cfgi2c_pkg::*;
#(
    parameter int NREG      = 28,
    parameter int PTR_W     = 8,
    parameter int CAP_DELAY = 3,
    parameter int OUT_DELAY = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [1:0]       addr_strap,
    output logic             sda_drive_low,
    output logic [PTR_W-1:0] reg_rd_addr,
    input  logic [7:0]       reg_rd_data,
    output logic             reg_wr_stb,
    output logic [PTR_W-1:0] reg_wr_addr,
    output logic [7:0]       reg_wr_data
);
    localparam logic [3:0]       LAST_BIT = 4'd8;
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(NREG);

    logic scl_f, sda_f, scl_d, sda_d;
    logic start_ev, stop_ev, rise_ev, fall_ev, cap_tick, upd_tick;

    phase_t           phase_q;
    logic [3:0]       bitcnt_q;
    logic             ack_q, rw_q, first_q, nack_q, drv_q;
    logic [7:0]       shreg_q, txbyte_q;
    logic [PTR_W-1:0] ptr_q;
    logic [7:0]       rd_value;
    logic             addr_match, ptr_ok;

    i2c_line_filter u_scl_flt (.clk(clk), .rst_n(rst_n), .line_in(scl_in), .line_out(scl_f));
    i2c_line_filter u_sda_flt (.clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_out(sda_f));

    // Previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    assign start_ev = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_ev  = scl_f & scl_d & ~sda_d & sda_f;
    assign rise_ev  = scl_f & ~scl_d;
    assign fall_ev  = ~scl_f & scl_d;

    i2c_delay_pulse #(.DELAY(CAP_DELAY)) u_cap_dly (.clk(clk), .rst_n(rst_n), .trig(rise_ev), .pulse(cap_tick));
    i2c_delay_pulse #(.DELAY(OUT_DELAY)) u_upd_dly (.clk(clk), .rst_n(rst_n), .trig(fall_ev), .pulse(upd_tick));

    assign ptr_ok     = (ptr_q < PTR_END);
    assign rd_value   = ptr_ok ? reg_rd_data : 8'h00;
    assign addr_match = (shreg_q[7:1] == {ADDR_PREFIX, addr_strap});

    // Transaction sequencing: bus events, bit capture and SDA updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q     <= PH_IDLE;
            bitcnt_q    <= '0;
            ack_q       <= 1'b0;
            rw_q        <= 1'b0;
            first_q     <= 1'b0;
            nack_q      <= 1'b0;
            drv_q       <= 1'b0;
            shreg_q     <= '0;
            txbyte_q    <= '0;
            ptr_q       <= '0;
            reg_wr_stb  <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_stb <= 1'b0;
            if (stop_ev) begin
                phase_q <= PH_IDLE;
                ack_q   <= 1'b0;
                drv_q   <= 1'b0;
            end else if (start_ev) begin
                phase_q  <= PH_ADDR;
                bitcnt_q <= '0;
                ack_q    <= 1'b0;
                drv_q    <= 1'b0;
                first_q  <= 1'b1;
            end else if (cap_tick) begin
                case (phase_q)
                    PH_ADDR, PH_WDATA: if (bitcnt_q < LAST_BIT) begin
                        shreg_q  <= {shreg_q[6:0], sda_f};
                        bitcnt_q <= bitcnt_q + 1'b1;
                    end
                    PH_RDATA: if (bitcnt_q < LAST_BIT) bitcnt_q <= bitcnt_q + 1'b1;
                              else                     nack_q   <= sda_f;
                    default: ;
                endcase
            end else if (upd_tick) begin
                case (phase_q)
                    PH_ADDR: if (bitcnt_q == LAST_BIT) begin
                        if (!ack_q) begin
                            if (addr_match) begin
                                ack_q <= 1'b1;
                                drv_q <= 1'b1;
                                rw_q  <= shreg_q[0];
                            end else begin
                                phase_q <= PH_WAIT;
                            end
                        end else begin
                            ack_q    <= 1'b0;
                            bitcnt_q <= '0;
                            if (rw_q) begin
                                phase_q  <= PH_RDATA;
                                txbyte_q <= rd_value;
                                drv_q    <= ~rd_value[7];
                            end else begin
                                phase_q <= PH_WDATA;
                                drv_q   <= 1'b0;
                            end
                        end
                    end
                    PH_WDATA: if (bitcnt_q == LAST_BIT) begin
                        if (!ack_q) begin
                            ack_q <= 1'b1;
                            drv_q <= 1'b1;
                            if (first_q) begin
                                ptr_q   <= PTR_W'(shreg_q);
                                first_q <= 1'b0;
                            end else begin
                                if (ptr_ok) begin
                                    reg_wr_stb  <= 1'b1;
                                    reg_wr_addr <= ptr_q;
                                    reg_wr_data <= shreg_q;
                                end
                                ptr_q <= ptr_q + 1'b1;
                            end
                        end else begin
                            ack_q    <= 1'b0;
                            drv_q    <= 1'b0;
                            bitcnt_q <= '0;
                        end
                    end
                    PH_RDATA: if (bitcnt_q == LAST_BIT) begin
                        if (!ack_q) begin
                            ack_q <= 1'b1;
                            drv_q <= 1'b0;
                            ptr_q <= ptr_q + 1'b1;
                        end else begin
                            ack_q <= 1'b0;
                            if (nack_q) begin
                                phase_q <= PH_WAIT;
                                drv_q   <= 1'b0;
                            end else begin
                                bitcnt_q <= '0;
                                txbyte_q <= rd_value;
                                drv_q    <= ~rd_value[7];
                            end
                        end
                    end else if (bitcnt_q != '0) begin
                        drv_q <= ~txbyte_q[3'(4'd7 - bitcnt_q)];
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_drive_low = drv_q;
    assign reg_rd_addr   = ptr_q;
endmodule

// File: rtl/cfg_i2c_target_chk.sv
// Property checker for cfg_i2c_target, attached by bind. Observes the
// filtered SCL level, the STOP event and the phase beside the ports.
module cfg_i2c_target_chk
    import cfgi2c_pkg::*;
#(
    parameter int NREG  = 28,
    parameter int PTR_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             start_ev,
    input logic             stop_ev,
    input phase_t           phase_q,
    input logic             sda_drive_low,
    input logic             reg_wr_stb,
    input logic [PTR_W-1:0] reg_wr_addr
);
    AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_drive_low) && !$past(start_ev) && !$past(stop_ev)) |-> !scl_f); // R8
    AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |-> (reg_wr_addr < PTR_W'(NREG))); // R6
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_stb |=> !reg_wr_stb); // R4
    AST_QUIET_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE || phase_q == PH_WAIT) |-> !sda_drive_low); // R2
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_drive_low); // R7
endmodule

bind cfg_i2c_target cfg_i2c_target_chk #(.NREG(NREG), .PTR_W(PTR_W)) u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .scl_f(scl_f),
    .start_ev(start_ev),
    .stop_ev(stop_ev),
    .phase_q(phase_q),
    .sda_drive_low(sda_drive_low),
    .reg_wr_stb(reg_wr_stb),
    .reg_wr_addr(reg_wr_addr)
);

// File: tb/tb_cfg_i2c_target.sv
// Bench: acts as bus host, keeps the register bank model and checks results.
module tb_cfg_i2c_target;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 16;
    localparam int NREG       = 28;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic [1:0] strap = 2'b00;
    logic       sda_drive_low, reg_wr_stb;
    logic [7:0] reg_rd_addr, reg_wr_addr, reg_wr_data, reg_rd_data;
    logic       sda_line;

    logic [7:0] mem [NREG];
    int checks = 0, errors = 0, stb_count = 0, r8_viol = 0;
    logic drv_prev = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_line    = sda_h & ~sda_drive_low;
    assign reg_rd_data = (reg_rd_addr < 8'(NREG)) ? mem[reg_rd_addr[4:0]] : 8'hAA;

    cfg_i2c_target dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_h), .sda_in(sda_line),
        .addr_strap(strap), .sda_drive_low(sda_drive_low),
        .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
        .reg_wr_stb(reg_wr_stb), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    // Register bank model and monitors, sampled away from the active edge.
    always @(negedge clk) begin
        if (reg_wr_stb) begin
            stb_count++;
            if (reg_wr_addr < 8'(NREG)) mem[reg_wr_addr[4:0]] = reg_wr_data;
        end
        if (rst_n && scl_h && (sda_drive_low != drv_prev)) r8_viol++;
        drv_prev = sda_drive_low;
    end

    function automatic logic [7:0] val(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic seen);
        sda_h = b;
        wait_clk(HP);
        scl_h = 1'b1;
        wait_clk(HP/2);
        seen = sda_line;
        wait_clk(HP/2);
        scl_h = 1'b0;
    endtask

    task automatic bus_start();
        sda_h = 1'b1;
        wait_clk(HP);
        scl_h = 1'b1;
        wait_clk(HP);
        sda_h = 1'b0;
        wait_clk(HP);
        scl_h = 1'b0;
    endtask

    task automatic bus_stop();
        sda_h = 1'b0;
        wait_clk(HP);
        scl_h = 1'b1;
        wait_clk(HP);
        sda_h = 1'b1;
        wait_clk(HP);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(v[i], s);
        clock_bit(1'b1, s);
        acked = !s;
    endtask

    task automatic recv_byte(input bit host_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            v[i] = s;
        end
        clock_bit(!host_ack, s);
    endtask

    initial begin
        bit         ack;
        logic [7:0] rb, exp_b;
        logic       s;
        int         stb_before;
        for (int i = 0; i < NREG; i++) mem[i] = 8'h00;
        wait_clk(5);
        chk(sda_drive_low == 1'b0 && reg_wr_stb == 1'b0, "R2 reset", int'(sda_drive_low), 0);
        rst_n = 1'b1;
        wait_clk(10);

        // R2: clocking without START is ignored
        strap = 2'b10;
        scl_h = 1'b0;
        wait_clk(HP);
        send_byte(8'h8C, ack);
        send_byte(8'h00, ack);
        chk(!ack && stb_count == 0, "R2 no start", int'(ack), 0);
        scl_h = 1'b1;
        sda_h = 1'b1;
        wait_clk(HP);
        bus_stop();

        // R1/R3: strap x low address bit sweep
        for (int st = 0; st < 4; st++) begin
            for (int lo = 0; lo < 4; lo++) begin
                strap = 2'(st);
                bus_start();
                send_byte({5'b10001, 2'(lo), 1'b0}, ack);
                chk(ack == (lo == st), "R1 R3 address match", int'(ack), int'(lo == st));
                bus_stop();
            end
        end
        // R1: wrong fixed prefix
        strap = 2'b10;
        bus_start();
        send_byte({5'b10011, 2'b10, 1'b0}, ack);
        chk(!ack, "R1 prefix", int'(ack), 0);
        bus_stop();

        // R4/R5/R10: fill all registers from pointer 0
        bus_start();
        send_byte(8'h8C, ack);
        send_byte(8'h00, ack);
        chk(ack, "R10 pointer byte ack", int'(ack), 1);
        for (int i = 0; i < NREG; i++) begin
            send_byte(val(i), ack);
            chk(ack, "R10 data ack", int'(ack), 1);
        end
        bus_stop();
        chk(stb_count == NREG, "R4 strobe count", stb_count, NREG);
        for (int i = 0; i < NREG; i++)
            chk(mem[i] == val(i), "R4 R5 written value", int'(mem[i]), int'(val(i)));

        // R6: write across the end of the map
        bus_start();
        send_byte(8'h8C, ack);
        send_byte(8'd27, ack);
        send_byte(8'h5A, ack);
        send_byte(8'hC3, ack);
        chk(ack, "R10 discarded byte ack", int'(ack), 1);
        bus_stop();
        chk(stb_count == NREG + 1, "R6 no strobe past end", stb_count, NREG + 1);
        chk(mem[27] == 8'h5A, "R6 last register", int'(mem[27]), 8'h5A);

        // R5/R6/R7: pointer write, repeated START, sequential read
        bus_start();
        send_byte(8'h8C, ack);
        send_byte(8'h00, ack);
        bus_start();
        send_byte(8'h8D, ack);
        chk(ack, "R3 R7 read address ack", int'(ack), 1);
        for (int i = 0; i < 30; i++) begin
            recv_byte(i < 29, rb);
            exp_b = (i < 27) ? val(i) : (i == 27) ? 8'h5A : 8'h00;
            chk(rb == exp_b, "R5 R6 read value", int'(rb), int'(exp_b));
        end
        bus_stop();
        chk(sda_drive_low == 1'b0, "R7 released after stop", int'(sda_drive_low), 0);

        // R9: NACK ends reading; line stays released
        bus_start();
        send_byte(8'h8C, ack);
        send_byte(8'd5, ack);
        bus_start();
        send_byte(8'h8D, ack);
        recv_byte(1'b0, rb);
        chk(rb == val(5), "R7 read after restart", int'(rb), int'(val(5)));
        for (int k = 0; k < 9; k++) begin
            clock_bit(1'b1, s);
            chk(s == 1'b1, "R9 released after nack", int'(s), 1);
        end
        bus_stop();

        // R2: after STOP, data clocks without START write nothing
        stb_before = stb_count;
        scl_h = 1'b0;
        wait_clk(HP);
        send_byte(8'h8C, ack);
        chk(!ack, "R2 ignored after stop", int'(ack), 0);
        send_byte(8'h01, ack);
        send_byte(8'h77, ack);
        chk(stb_count == stb_before, "R2 no write after stop", stb_count, stb_before);
        scl_h = 1'b1;
        wait_clk(HP);
        bus_stop();

        chk(r8_viol == 0, "R8 drive change while SCL high", r8_viol, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule